// File: doc/BRIEF.md
# Single-Channel DMA Engine with End-of-Transfer Handling

The block is one DMA channel. Software programs a current source address, a current destination address and a byte count through a small register port. While the channel is enabled and a transfer request is present, the block moves one data word at a time. It reads the word at the source address and writes it to the destination address. After each beat, both addresses advance by the word size in bytes and the count drops by the same amount.

A transfer is complete when the beat that takes the count to zero is written. At that point the block runs a fixed set of actions:

- It latches a sticky completion flag.
- It loads the count again from a reload register.
- It reloads the source address and the destination address from their own reload registers, each only if that address has its reload option set.
- It can clear its own enable.
- It can give a one-cycle end strobe.

The interrupt request is a level: the completion flag gated by an interrupt enable.

The memory side is a read-command channel, a read-response channel and a write channel, each valid/ready:

- A valid, once raised, holds its address and data steady until the matching ready is seen.
- The engine holds back no data. It raises `rd_rsp_ready` only while it waits for read data.
- A beat ends on the write handshake.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, every register reads zero, and `irq`, `end_pulse`, `rd_cmd_valid` and `wr_valid` are low.
- R2: Each beat reads the word at the current source address and writes that word to the current destination address. Both addresses then grow by DATA_W/8 bytes and the count shrinks by DATA_W/8.
- R3: The completion flag (bit 0 of the status register, register 1) sets in the cycle after the beat that brings the count to zero. It stays set until software writes 1 to that bit. Writing 0 has no effect.
- R4: `irq` equals the completion flag ANDed with the interrupt enable (control bit 4).
- R5: `end_pulse` is high for exactly one cycle, in the cycle after the completing beat, and only when the end-strobe enable (control bit 5) is set.
- R6: At completion, the channel enable (control bit 0) drops to 0 when the auto-off bit (control bit 1) is 1, and no further beats start. With auto-off at 0, the enable stays set and transfers continue.
- R7: At every completion, the current count (register 4) is loaded from the reload count (register 7).
- R8: At completion, the current source address (register 2) is loaded from the reload source (register 5) if control bit 2 is set. The current destination address (register 3) is loaded from the reload destination (register 6) if control bit 3 is set. An address without its reload bit keeps advancing past the last beat.
- R9: A beat starts only while the enable is 1, `xfer_req` is high and the current count is non-zero.
- R10: If a completion and a software clear of the flag fall in the same cycle, the flag ends set.
- R11: `rd_cmd_valid` and `wr_valid` stay high, with stable address and data, until their ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for reads and writes |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data, combinational on `reg_addr` |
| xfer_req | input | 1 | Transfer request level |
| rd_cmd_valid | output | 1 | Read command valid |
| rd_cmd_ready | input | 1 | Read command accepted |
| rd_cmd_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine can take read data |
| rd_rsp_data | input | DATA_W | Read data |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | DATA_W | Write data |
| end_pulse | output | 1 | One-cycle end-of-transfer strobe |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a completing beat that lands in the same clock edge as a software write that clears the flag. The bench reaches it as follows:

- It leaves the flag set from an earlier transfer.
- It starts a one-beat transfer and holds `wr_ready` low, which parks the engine with its write pending.
- At a single falling edge, it releases `wr_ready` and issues the status clear together.

Back-pressure on both memory channels is made with a ready pattern that toggles cycle by cycle. Reload with auto-restart is shown by leaving the request high across two back-to-back transfers.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL = 3'd0,
    RA_STAT = 3'd1,
    RA_CSRC = 3'd2,
    RA_CDST = 3'd3,
    RA_CCNT = 3'd4,
    RA_RSRC = 3'd5,
    RA_RDST = 3'd6,
    RA_RCNT = 3'd7
  } reg_addr_e;

  // control register, bit 0 at the right
  typedef struct packed {
    logic end_en;    // bit 5
    logic irq_en;    // bit 4
    logic dst_rld;   // bit 3
    logic src_rld;   // bit 2
    logic auto_off;  // bit 1
    logic en;        // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RCMD = 2'd1,
    ST_RRSP = 2'd2,
    ST_WR   = 2'd3
  } eng_state_e;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              beat_done,
  output logic              xfer_done,
  output ctrl_t             ctrl,
  output logic              done_flag,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt
);
  localparam int BEAT_B = DATA_W / 8;

  logic [ADDR_W-1:0] rld_src, rld_dst;
  logic [CNT_W-1:0]  rld_cnt, cnt_next;

  function automatic logic hit(input logic [REG_AW-1:0] a, input reg_addr_e r);
    return a == r;
  endfunction

  assign cnt_next  = (cur_cnt <= CNT_W'(BEAT_B)) ? '0 : cur_cnt - CNT_W'(BEAT_B);
  assign xfer_done = beat_done && (cnt_next == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else begin
      if (wr_en && hit(addr, RA_CTRL)) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (xfer_done && ctrl.auto_off) ctrl.en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                      done_flag <= 1'b0;
    else if (xfer_done)                              done_flag <= 1'b1;
    else if (wr_en && hit(addr, RA_STAT) && wdata[0]) done_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_src <= '0;
      cur_dst <= '0;
      cur_cnt <= '0;
    end else if (beat_done) begin
      cur_src <= (xfer_done && ctrl.src_rld) ? rld_src : cur_src + ADDR_W'(BEAT_B);
      cur_dst <= (xfer_done && ctrl.dst_rld) ? rld_dst : cur_dst + ADDR_W'(BEAT_B);
      cur_cnt <= xfer_done ? rld_cnt : cnt_next;
    end else if (wr_en) begin
      if (hit(addr, RA_CSRC)) cur_src <= wdata[ADDR_W-1:0];
      if (hit(addr, RA_CDST)) cur_dst <= wdata[ADDR_W-1:0];
      if (hit(addr, RA_CCNT)) cur_cnt <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_src <= '0;
      rld_dst <= '0;
      rld_cnt <= '0;
    end else if (wr_en) begin
      if (hit(addr, RA_RSRC)) rld_src <= wdata[ADDR_W-1:0];
      if (hit(addr, RA_RDST)) rld_dst <= wdata[ADDR_W-1:0];
      if (hit(addr, RA_RCNT)) rld_cnt <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      RA_CTRL: rdata = REG_W'(ctrl);
      RA_STAT: rdata = REG_W'(done_flag);
      RA_CSRC: rdata = REG_W'(cur_src);
      RA_CDST: rdata = REG_W'(cur_dst);
      RA_CCNT: rdata = REG_W'(cur_cnt);
      RA_RSRC: rdata = REG_W'(rld_src);
      RA_RDST: rdata = REG_W'(rld_dst);
      RA_RCNT: rdata = REG_W'(rld_cnt);
      default: rdata = '0;
    endcase
  end

  AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> done_flag); // R10
  AST_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl.auto_off) |=> !ctrl.en); // R6
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (cur_cnt == $past(rld_cnt))); // R7
  AST_SRC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl.src_rld) |=> (cur_src == $past(rld_src))); // R8
  AST_DST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && ctrl.dst_rld) |=> (cur_dst == $past(rld_dst))); // R8
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              req,
  input  logic              cnt_nz,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  output logic              rd_cmd_valid,
  input  logic              rd_cmd_ready,
  output logic [ADDR_W-1:0] rd_cmd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              beat_done
);
  eng_state_e        state;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (en && req && cnt_nz) begin
          src_q <= src;
          dst_q <= dst;
          state <= ST_RCMD;
        end
        ST_RCMD: if (rd_cmd_ready) state <= ST_RRSP;
        ST_RRSP: if (rd_rsp_valid) begin
          data_q <= rd_rsp_data;
          state  <= ST_WR;
        end
        ST_WR:   if (wr_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rd_cmd_valid = (state == ST_RCMD);
  assign rd_cmd_addr  = src_q;
  assign rd_rsp_ready = (state == ST_RRSP);
  assign wr_valid     = (state == ST_WR);
  assign wr_addr      = dst_q;
  assign wr_data      = data_q;
  assign beat_done    = wr_valid && wr_ready;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd_valid && !rd_cmd_ready) |=> (rd_cmd_valid && $stable(rd_cmd_addr))); // R11
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R11
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_cmd_valid) |-> ($past(en) && $past(req) && $past(cnt_nz))); // R9
endmodule

// File: rtl/dma_chan_endctl.sv
module dma_chan_endctl (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_done,
  input  logic end_en,
  input  logic irq_en,
  input  logic done_flag,
  output logic end_pulse,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) end_pulse <= 1'b0;
    else        end_pulse <= xfer_done && end_en;
  end

  assign irq = done_flag && irq_en;

  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |=> !end_pulse); // R5
  AST_END_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> done_flag); // R3
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              xfer_req,
  output logic              rd_cmd_valid,
  input  logic              rd_cmd_ready,
  output logic [ADDR_W-1:0] rd_cmd_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              end_pulse,
  output logic              irq
);
  ctrl_t             ctrl;
  logic              done_flag, beat_done, xfer_done;
  logic [ADDR_W-1:0] cur_src, cur_dst;
  logic [CNT_W-1:0]  cur_cnt;

  dma_chan_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .beat_done(beat_done), .xfer_done(xfer_done),
    .ctrl(ctrl), .done_flag(done_flag),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt)
  );

  dma_chan_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .en(ctrl.en), .req(xfer_req), .cnt_nz(cur_cnt != '0),
    .src(cur_src), .dst(cur_dst),
    .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .beat_done(beat_done)
  );

  dma_chan_endctl endctl_i (
    .clk(clk), .rst_n(rst_n),
    .xfer_done(xfer_done), .end_en(ctrl.end_en), .irq_en(ctrl.irq_en),
    .done_flag(done_flag), .end_pulse(end_pulse), .irq(irq)
  );
endmodule

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_req = 1'b0;
  logic        rd_cmd_valid, rd_cmd_ready;
  logic [31:0] rd_cmd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic        rd_rsp_ready;
  logic [31:0] rd_rsp_data = '0;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr, wr_data;
  logic        end_pulse, irq;

  logic        bp = 1'b0;
  logic        hold_wr = 1'b0;
  logic [7:0]  cyc = '0;
  logic [7:0]  log_n = '0;
  logic [7:0]  rd_n = '0;
  logic [7:0]  end_n = '0;
  logic        end_prev = 1'b0;
  logic        end_long = 1'b0;
  logic        hold_err = 1'b0;
  logic        pv_wr = 1'b0, pv_rd = 1'b0;
  logic [31:0] pv_waddr = '0, pv_wdata = '0, pv_raddr = '0;
  logic [31:0] log_a [16];
  logic [31:0] log_d [16];
  int          checks = 0;
  int          errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_req(xfer_req),
    .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready), .rd_cmd_addr(rd_cmd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .end_pulse(end_pulse), .irq(irq)
  );

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  assign rd_cmd_ready = !bp || cyc[0];
  assign wr_ready     = !hold_wr && (!bp || cyc[1]);

  // memory model and monitors
  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0;
    end else begin
      if (rd_cmd_valid && rd_cmd_ready) begin
        rd_rsp_valid <= 1'b1;
        rd_rsp_data  <= mem_val(rd_cmd_addr);
        rd_n <= rd_n + 8'd1;
      end else if (rd_rsp_valid && rd_rsp_ready) begin
        rd_rsp_valid <= 1'b0;
      end
      if (wr_valid && wr_ready) begin
        log_a[log_n[3:0]] <= wr_addr;
        log_d[log_n[3:0]] <= wr_data;
        log_n <= log_n + 8'd1;
      end
      if (end_pulse) end_n <= end_n + 8'd1;
      if (end_pulse && end_prev) end_long <= 1'b1;
      end_prev <= end_pulse;
      if (pv_wr && !(wr_valid && wr_addr == pv_waddr && wr_data == pv_wdata)) hold_err <= 1'b1;
      if (pv_rd && !(rd_cmd_valid && rd_cmd_addr == pv_raddr)) hold_err <= 1'b1;
      pv_wr <= wr_valid && !wr_ready;
      pv_rd <= rd_cmd_valid && !rd_cmd_ready;
      pv_waddr <= wr_addr;
      pv_wdata <= wr_data;
      pv_raddr <= rd_cmd_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int i = 0; i < 8; i++) begin
      reg_read(3'(i), d);
      check("R1 register zero", d, 32'h0);
    end
    check("R1 irq low", {31'd0, irq}, 32'h0);
    check("R1 end_pulse low", {31'd0, end_pulse}, 32'h0);
    check("R1 valids low", {30'd0, rd_cmd_valid, wr_valid}, 32'h0);
  endtask

  task automatic t_basic_autooff;
    logic [31:0] d;
    reg_write(3'd2, 32'h100);
    reg_write(3'd3, 32'h200);
    reg_write(3'd4, 32'd16);
    reg_write(3'd5, 32'h1000);
    reg_write(3'd6, 32'h2000);
    reg_write(3'd7, 32'd8);
    reg_write(3'd0, 32'h33); // en, auto_off, irq_en, end_en
    xfer_req = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (end_n != 0) break;
    end
    wait_cycles(30);
    check("R6 no beats after auto-off", {24'd0, log_n}, 32'd4);
    for (int i = 0; i < 4; i++) begin
      check("R2 write address", log_a[i], 32'h200 + 32'(4*i));
      check("R2 write data", log_d[i], mem_val(32'h100 + 32'(4*i)));
    end
    check("R5 one end pulse", {24'd0, end_n}, 32'd1);
    check("R5 pulse one cycle", {31'd0, end_long}, 32'd0);
    check("R4 irq with enable", {31'd0, irq}, 32'd1);
    reg_read(3'd1, d); check("R3 flag set", d, 32'd1);
    reg_read(3'd0, d); check("R6 enable cleared", d, 32'h32);
    reg_read(3'd4, d); check("R7 count reloaded", d, 32'd8);
    reg_read(3'd2, d); check("R8 src not reloaded", d, 32'h110);
    reg_read(3'd3, d); check("R8 dst not reloaded", d, 32'h210);
    xfer_req = 1'b0;
  endtask

  task automatic t_flag_clear;
    logic [31:0] d;
    reg_write(3'd1, 32'd0);
    reg_read(3'd1, d); check("R3 write 0 keeps flag", d, 32'd1);
    reg_write(3'd1, 32'd1);
    reg_read(3'd1, d); check("R3 write 1 clears flag", d, 32'd0);
    check("R4 irq follows flag", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_reload_restart;
    logic [31:0] d;
    bp = 1'b1;
    reg_write(3'd2, 32'h300);
    reg_write(3'd3, 32'h400);
    reg_write(3'd4, 32'd8);
    reg_write(3'd5, 32'h500);
    reg_write(3'd6, 32'h600);
    reg_write(3'd7, 32'd8);
    reg_write(3'd0, 32'h0D); // en, src_rld, dst_rld
    xfer_req = 1'b1;
    for (int i = 0; i < 600; i++) begin
      if (log_n == 8'd8) break;
      @(posedge clk); #1;
    end
    @(negedge clk);
    xfer_req = 1'b0;
    wait_cycles(30);
    check("R9 no beats without request", {24'd0, log_n}, 32'd8);
    check("R2 addr beat a", log_a[4], 32'h400);
    check("R2 addr beat b", log_a[5], 32'h404);
    check("R8 dst reload addr", log_a[6], 32'h600);
    check("R8 dst reload addr 2", log_a[7], 32'h604);
    check("R2 data beat a", log_d[5], mem_val(32'h304));
    check("R8 src reload data", log_d[6], mem_val(32'h500));
    check("R8 src reload data 2", log_d[7], mem_val(32'h504));
    check("R5 no pulse when disabled", {24'd0, end_n}, 32'd1);
    check("R4 irq gated off", {31'd0, irq}, 32'd0);
    reg_read(3'd1, d); check("R3 flag after reload run", d, 32'd1);
    reg_read(3'd0, d); check("R6 enable kept", d, 32'h0D);
    reg_read(3'd2, d); check("R8 src reloaded", d, 32'h500);
    reg_read(3'd3, d); check("R8 dst reloaded", d, 32'h600);
    reg_read(3'd4, d); check("R7 count reloaded again", d, 32'd8);
    check("R11 valid held under back-pressure", {31'd0, hold_err}, 32'd0);
    bp = 1'b0;
  endtask

  task automatic t_done_vs_clear;
    logic [31:0] d;
    hold_wr = 1'b1;
    reg_write(3'd2, 32'h700);
    reg_write(3'd3, 32'h800);
    reg_write(3'd4, 32'd4);
    reg_write(3'd0, 32'h21); // en, end_en
    xfer_req = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wr_valid) break;
    end
    xfer_req = 1'b0;
    hold_wr = 1'b0;
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'd1;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    check("R10 completion beats clear", reg_rdata, 32'd1);
    check("R5 pulse in cycle after beat", {31'd0, end_pulse}, 32'd1);
    check("R2 single beat address", log_a[8], 32'h800);
    check("R2 single beat data", log_d[8], mem_val(32'h700));
    @(negedge clk);
    check("R5 pulse drops", {31'd0, end_pulse}, 32'd0);
    reg_write(3'd1, 32'd1);
    reg_read(3'd1, d); check("R3 later clear works", d, 32'd0);
  endtask

  task automatic t_gating;
    logic [7:0] r0;
    r0 = rd_n;
    reg_write(3'd0, 32'h0);
    reg_write(3'd4, 32'd8);
    xfer_req = 1'b1;
    wait_cycles(30);
    check("R9 disabled channel idle", {24'd0, rd_n}, {24'd0, r0});
    reg_write(3'd4, 32'd0);
    reg_write(3'd0, 32'h1);
    wait_cycles(30);
    check("R9 zero count idle", {24'd0, rd_n}, {24'd0, r0});
    xfer_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_autooff();
    t_flag_clear();
    t_reload_restart();
    t_done_vs_clear();
    t_gating();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule